// File: doc/BRIEF.md
# Write-Leveling Training Sequencer

This block carries out the write-leveling step of DRAM bring-up. For every data-strobe lane in turn it issues a mode-register write that switches the memories into leveling mode. It then sends short bursts of strobe pulses on that lane while sweeping the lane's programmable strobe delay upward one tap at a time. During leveling the memory samples its own clock with the strobe edge and reports the sampled level back on the data bus. The sequencer takes a majority vote over the samples of each burst and locks the lane's delay at the first tap where the reported level has gone from 0 to 1. That tap is where the strobe lines up with the clock at that device, which keeps the clock-to-strobe skew window satisfied for writes.

After every lane has been processed, one final mode-register write takes the memories out of leveling mode, and a one-cycle completion pulse is raised. A lane that reaches its top tap without showing a 0-to-1 change is marked failed. Its delay is returned to 0 and the sequence moves on, and a sticky error output records that at least one lane failed. The locked delays stay on the per-lane delay outputs for the analog delay lines to use.

Top module: `wlvl_seq`

## Requirements
- R1: After reset, `done`, `err`, `mr_valid`, every `dqs_pulse` bit, every `lane_fail` bit and every delay field are 0.
- R2: When `start` is seen while idle, the block issues, once for each lane in ascending lane order, a mode-register write with `mr_sel` = 1 and `mr_value` = 16'h0080 (bit 7 set = leveling on). `mr_valid` is held, with `mr_value` stable, until a cycle in which `mr_ready` is 1.
- R3: After the last lane is finished, exactly one further write with `mr_sel` = 1 and `mr_value` = 16'h0000 (bit 7 clear = leveling off) is issued before `done`.
- R4: The wait length is L = max(`wait_cycles`, 16). After the accepted enter write there are exactly L cycles without strobe pulses before the first burst. Between two bursts of the same lane there are exactly L+1 pulse-free cycles. No pulse is sent while `mr_valid` is 1.
- R5: Each burst asserts `dqs_pulse` for exactly 3 consecutive cycles (the default sample count). The pulse is only on the lane under training (bit i = lane i, at most one bit set), and lanes are trained in ascending order.
- R6: The level of a tap is the majority of the `lvl_fb` values of the trained lane sampled in the cycles of that burst. A single wrong sample in a burst does not change any result.
- R7: A lane's delay (field i of `dly_tap`, bits i*5 to i*5+4) starts at 0 and rises by one tap per burst. The first tap whose majority is 1, after some earlier tap of that lane gave 0, is kept on that field, so a lane whose level turns 1 at tap t (1 <= t <= 31) ends at delay t after t+1 bursts.
- R8: If tap 31 is reached without such a 0-to-1 change (level already 1 at tap 0, or never 1), `lane_fail` bit i is set, the lane's delay returns to 0 after 32 bursts, and training continues with the next lane.
- R9: `done` is 1 for exactly one cycle at the end of a run. `err` equals the OR of `lane_fail`. It stays set until the next accepted `start`, which clears it.
- R10: `start` is ignored while a run is in progress. The run does not restart and issues no extra enter write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a training run (accepted when idle) |
| wait_cycles | input | 8 | Settle wait after a mode write or tap change, at least 16 is used |
| mr_valid | output | 1 | Mode-register write request |
| mr_ready | input | 1 | Mode-register write accepted |
| mr_sel | output | 3 | Mode-register index (always 1) |
| mr_value | output | 16 | Mode-register data, bit 7 = leveling enable |
| dly_tap | output | 20 | Per-lane strobe delay, lane i in bits i*5 +: 5 |
| dqs_pulse | output | 4 | Per-lane strobe pulse enable |
| lvl_fb | input | 4 | Per-lane clock level sampled by the memory |
| done | output | 1 | One-cycle end-of-run pulse |
| err | output | 1 | Sticky: some lane failed in the last run |
| lane_fail | output | 4 | Per-lane failure flags of the last run |

## Verification
A wrong tap counter or a stale seen-zero flag shows up as a delay field that differs from the lane's modelled threshold, and as a per-lane burst count that is off at the end-of-run pulse. A wrong wait or vote counter is visible within one burst, through a pulse-free gap or burst length that differs from the expected one. The bench memory model flips one sample per burst, rotating which one, so a vote that follows any single sample gives a wrong lock tap. The mode-register queue is compared at every accepted write, so a restart or a missing exit write is reported at the handshake where it happens.

// File: rtl/wlvl_pkg.sv
package wlvl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_MR_ON,
        ST_WAIT,
        ST_SAMP,
        ST_DECIDE,
        ST_MR_OFF,
        ST_FIN
    } wl_state_e;

    localparam int          MR_W         = 16;
    localparam logic [2:0]  MR_LEVEL_SEL = 3'd1;
    localparam int          LEVEL_BIT    = 7;

    typedef struct packed {
        logic lock;
        logic fail;
        logic step;
    } wl_verdict_t;

    function automatic logic [MR_W-1:0] mr_word(input logic level_on);
        logic [MR_W-1:0] w;
        w = '0;
        w[LEVEL_BIT] = level_on;
        return w;
    endfunction

    function automatic wl_verdict_t judge(input logic maj, input logic seen0, input logic at_top);
        wl_verdict_t v;
        v.lock = maj & seen0;
        v.fail = ~v.lock & at_top;
        v.step = ~v.lock & ~at_top;
        return v;
    endfunction

endpackage

// File: rtl/wlvl_wait_timer.sv
module wlvl_wait_timer #(
    parameter int WAIT_W   = 8,
    parameter int MIN_WAIT = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic [WAIT_W-1:0] wait_cycles,
    output logic              expired
);
    logic [WAIT_W-1:0] cnt_q;
    logic [WAIT_W-1:0] lim;

    assign lim     = (wait_cycles < WAIT_W'(MIN_WAIT)) ? WAIT_W'(MIN_WAIT) : wait_cycles;
    assign expired = run && (cnt_q == lim - WAIT_W'(1));

    always_ff @(posedge clk) begin
        if (rst || !run) cnt_q <= '0;
        else             cnt_q <= cnt_q + WAIT_W'(1);
    end

    // R4: the wait never ends in its first cycle
    p_wait_min_r4: assert property (@(posedge clk) disable iff (rst)
        expired |-> $past(run));

endmodule

// File: rtl/wlvl_vote.sv
module wlvl_vote #(
    parameter int SAMPLES = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic en,
    input  logic bit_in,
    output logic last,
    output logic maj
);
    localparam int CW = $clog2(SAMPLES + 1);

    logic [CW-1:0] ones_q;
    logic [CW-1:0] seen_q;

    assign last = en && (seen_q == CW'(SAMPLES - 1));
    assign maj  = (int'(ones_q) * 2) > SAMPLES;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            ones_q <= '0;
            seen_q <= '0;
        end else if (en) begin
            ones_q <= ones_q + CW'(bit_in);
            seen_q <= seen_q + CW'(1);
        end
    end

    // R6: the vote never counts more ones than samples
    p_ones_bound_r6: assert property (@(posedge clk) disable iff (rst)
        int'(ones_q) <= int'(seen_q));

endmodule

// File: rtl/wlvl_lane_bank.sv
module wlvl_lane_bank #(
    parameter int NUM_LANES = 4,
    parameter int TAP_W     = 5,
    parameter int LANE_W    = 2
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       clear_all,
    input  logic [LANE_W-1:0]          sel,
    input  logic                       inc,
    input  logic                       zero,
    output logic [TAP_W-1:0]           cur_tap,
    output logic [NUM_LANES*TAP_W-1:0] taps_flat
);
    logic [TAP_W-1:0] tap_q [NUM_LANES];

    assign cur_tap = tap_q[sel];

    for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst || clear_all)               tap_q[l] <= '0;
            else if (sel == LANE_W'(l)) begin
                if (zero)     tap_q[l] <= '0;
                else if (inc) tap_q[l] <= tap_q[l] + TAP_W'(1);
            end
        end
        assign taps_flat[l*TAP_W +: TAP_W] = tap_q[l];

        // R7: a lane's delay only climbs by one tap or falls back to zero
        p_tap_step_r7: assert property (@(posedge clk) disable iff (rst)
            !$stable(tap_q[l]) |-> (tap_q[l] == $past(tap_q[l]) + TAP_W'(1)) || (tap_q[l] == '0));
    end

endmodule

// File: rtl/wlvl_seq.sv
module wlvl_seq
    import wlvl_pkg::*;
#(
    parameter int NUM_LANES = 4,
    parameter int TAP_W     = 5,
    parameter int SAMPLES   = 3,
    parameter int WAIT_W    = 8,
    parameter int MIN_WAIT  = 16
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       start,
    input  logic [WAIT_W-1:0]          wait_cycles,
    output logic                       mr_valid,
    input  logic                       mr_ready,
    output logic [2:0]                 mr_sel,
    output logic [15:0]                mr_value,
    output logic [NUM_LANES*TAP_W-1:0] dly_tap,
    output logic [NUM_LANES-1:0]       dqs_pulse,
    input  logic [NUM_LANES-1:0]       lvl_fb,
    output logic                       done,
    output logic                       err,
    output logic [NUM_LANES-1:0]       lane_fail
);
    localparam int               LANE_W   = (NUM_LANES > 1) ? $clog2(NUM_LANES) : 1;
    localparam logic [LANE_W-1:0] LAST_LN = LANE_W'(NUM_LANES - 1);
    localparam logic [TAP_W-1:0]  TOP_TAP = '1;

    wl_state_e            state_q;
    logic [LANE_W-1:0]    lane_q;
    logic                 seen0_q;
    logic [NUM_LANES-1:0] fail_q;

    logic             expired, vote_last, vote_maj;
    logic [TAP_W-1:0] cur_tap;
    wl_verdict_t      verdict;
    logic             accept_start;

    assign accept_start = (state_q == ST_IDLE) && start;
    assign verdict      = judge(vote_maj, seen0_q, cur_tap == TOP_TAP);

    wlvl_wait_timer #(.WAIT_W(WAIT_W), .MIN_WAIT(MIN_WAIT)) u_timer (
        .clk(clk), .rst(rst), .run(state_q == ST_WAIT),
        .wait_cycles(wait_cycles), .expired(expired));

    wlvl_vote #(.SAMPLES(SAMPLES)) u_vote (
        .clk(clk), .rst(rst), .clr(state_q == ST_WAIT), .en(state_q == ST_SAMP),
        .bit_in(lvl_fb[lane_q]), .last(vote_last), .maj(vote_maj));

    wlvl_lane_bank #(.NUM_LANES(NUM_LANES), .TAP_W(TAP_W), .LANE_W(LANE_W)) u_bank (
        .clk(clk), .rst(rst), .clear_all(accept_start), .sel(lane_q),
        .inc(state_q == ST_DECIDE && verdict.step),
        .zero(state_q == ST_DECIDE && verdict.fail),
        .cur_tap(cur_tap), .taps_flat(dly_tap));

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            lane_q  <= '0;
            seen0_q <= 1'b0;
            fail_q  <= '0;
        end else begin
            case (state_q)
                ST_IDLE: if (start) begin
                    fail_q  <= '0;
                    lane_q  <= '0;
                    state_q <= ST_MR_ON;
                end
                ST_MR_ON: if (mr_ready) begin
                    seen0_q <= 1'b0;
                    state_q <= ST_WAIT;
                end
                ST_WAIT: if (expired) state_q <= ST_SAMP;
                ST_SAMP: if (vote_last) state_q <= ST_DECIDE;
                ST_DECIDE: begin
                    if (verdict.lock || verdict.fail) begin
                        if (verdict.fail) fail_q[lane_q] <= 1'b1;
                        if (lane_q == LAST_LN) state_q <= ST_MR_OFF;
                        else begin
                            lane_q  <= lane_q + LANE_W'(1);
                            state_q <= ST_MR_ON;
                        end
                    end else begin
                        if (!vote_maj) seen0_q <= 1'b1;
                        state_q <= ST_WAIT;
                    end
                end
                ST_MR_OFF: if (mr_ready) state_q <= ST_FIN;
                ST_FIN:    state_q <= ST_IDLE;
                default:   state_q <= ST_IDLE;
            endcase
        end
    end

    assign mr_valid  = (state_q == ST_MR_ON) || (state_q == ST_MR_OFF);
    assign mr_sel    = MR_LEVEL_SEL;
    assign mr_value  = mr_word(state_q == ST_MR_ON);
    assign dqs_pulse = (state_q == ST_SAMP) ? (NUM_LANES'(1) << lane_q) : '0;
    assign done      = (state_q == ST_FIN);
    assign lane_fail = fail_q;
    assign err       = |fail_q;

    // R2: a pending mode write holds its request and data
    p_mr_hold_r2: assert property (@(posedge clk) disable iff (rst)
        mr_valid && !mr_ready |=> mr_valid && $stable(mr_value));

    // R5: at most one lane pulses
    p_pulse_onehot_r5: assert property (@(posedge clk) disable iff (rst)
        $onehot0(dqs_pulse));

    // R4: no strobe pulse while a mode write is pending
    p_quiet_mr_r4: assert property (@(posedge clk) disable iff (rst)
        mr_valid |-> dqs_pulse == '0);

    // R9: done is a single-cycle pulse
    p_done_once_r9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R9: the error flag only clears on a new start
    p_err_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        err && !start |=> err);

endmodule

// File: tb/test_wlvl_seq.sv
`timescale 1ns/1ps
module test_wlvl_seq;
    localparam int L    = 4;
    localparam int TW   = 5;
    localparam int MAXT = 31;
    localparam int NS   = 3;
    localparam int WW   = 8;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            start = 1'b0;
    logic [WW-1:0]   wait_cycles = 8'd20;
    logic            mr_valid;
    logic            mr_ready = 1'b0;
    logic [2:0]      mr_sel;
    logic [15:0]     mr_value;
    logic [L*TW-1:0] dly_tap;
    logic [L-1:0]    dqs_pulse;
    logic [L-1:0]    lvl_fb;
    logic            done, err;
    logic [L-1:0]    lane_fail;

    always #2.5 clk = ~clk;

    wlvl_seq i_wlvl_seq (
        .clk(clk), .rst(rst), .start(start), .wait_cycles(wait_cycles),
        .mr_valid(mr_valid), .mr_ready(mr_ready), .mr_sel(mr_sel), .mr_value(mr_value),
        .dly_tap(dly_tap), .dqs_pulse(dqs_pulse), .lvl_fb(lvl_fb),
        .done(done), .err(err), .lane_fail(lane_fail));

    int total = 0, bad = 0, cycles = 0;
    int thr[L];
    int got_pulses[L];
    int lim = 20;
    bit noise_en = 0;
    logic [L-1:0] noise_q = '0;
    int rot = 0;
    int rdy_delay = 0, rdy_wait = 0;
    int mrq[$];
    int enter_cnt = 0, cur_lane = 0;
    int burst_len = 0, gap_cnt = 0, gap_exp = 0;
    bit in_burst = 0, run_done = 0, prev_done = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // memory model: level turns 1 at the lane's threshold tap
    always_comb begin
        for (int l = 0; l < L; l++)
            lvl_fb[l] = (int'(dly_tap[l*TW +: TW]) >= thr[l]) ^ noise_q[l];
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 0);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // cycle monitor and reference model
    always @(negedge clk) begin
        bit hs;
        int e;
        hs = 0;
        noise_q = '0;
        if (!rst) begin
            if (mr_valid) begin
                if (rdy_wait >= rdy_delay) mr_ready = 1'b1;
                else begin mr_ready = 1'b0; rdy_wait++; end
            end else begin
                mr_ready = 1'b0; rdy_wait = 0;
            end
            chk(!(mr_valid && dqs_pulse != 0), "R4 pulse during mode write", int'(dqs_pulse), 0);
            if (mr_valid && mr_ready) begin
                hs = 1;
                chk(mr_sel == 3'd1, "R2 mode register index", int'(mr_sel), 1);
                if (mrq.size() == 0) chk(0, "R2/R3 unexpected mode write", int'(mr_value), -1);
                else begin
                    e = mrq.pop_front();
                    if (e == 0) chk(int'(mr_value) == e, "R3 exit write value", int'(mr_value), e);
                    else        chk(int'(mr_value) == e, "R2 enter write value", int'(mr_value), e);
                    if (e == 'h80) begin enter_cnt++; cur_lane = enter_cnt - 1; end
                end
                gap_cnt = 0; gap_exp = lim;
            end
            if (dqs_pulse != 0) begin
                if (!in_burst) begin
                    chk(dqs_pulse == L'(1 << cur_lane), "R5 pulse lane", int'(dqs_pulse), 1 << cur_lane);
                    if (gap_exp > 0) chk(gap_cnt == gap_exp, "R4 pulse-free gap", gap_cnt, gap_exp);
                    in_burst = 1; burst_len = 0;
                end
                if (noise_en && burst_len == rot % NS && cur_lane < L) noise_q[cur_lane] = 1'b1;
                burst_len++;
                if (cur_lane < L) got_pulses[cur_lane]++;
            end else begin
                if (in_burst) begin
                    chk(burst_len == NS, "R5 burst length", burst_len, NS);
                    in_burst = 0; rot++;
                    gap_exp = lim + 1; gap_cnt = 1;
                end else if (!hs) gap_cnt++;
            end
            if (prev_done && done) chk(0, "R9 done longer than one cycle", 1, 0);
            if (done && !prev_done) begin
                bit any_fail;
                any_fail = 0;
                for (int l = 0; l < L; l++) begin
                    bit f;
                    int et, ep;
                    f  = !(thr[l] >= 1 && thr[l] <= MAXT);
                    et = f ? 0 : thr[l];
                    ep = (f ? MAXT + 1 : thr[l] + 1) * NS;
                    any_fail |= f;
                    if (f) chk(int'(dly_tap[l*TW +: TW]) == et, "R8 failed lane delay", int'(dly_tap[l*TW +: TW]), et);
                    else   chk(int'(dly_tap[l*TW +: TW]) == et, "R7 locked delay", int'(dly_tap[l*TW +: TW]), et);
                    chk(lane_fail[l] == f, "R8 lane fail flag", int'(lane_fail[l]), int'(f));
                    chk(got_pulses[l] == ep, "R6 R7 pulses on lane", got_pulses[l], ep);
                end
                chk(err == any_fail, "R9 error flag", int'(err), int'(any_fail));
                chk(mrq.size() == 0, "R3 pending mode writes", mrq.size(), 0);
                chk(enter_cnt == L, "R2 R10 enter writes", enter_cnt, L);
                run_done = 1;
            end
            prev_done = done;
        end
    end

    task automatic run(input int t0, input int t1, input int t2, input int t3,
                       input int wcyc, input bit noisy, input int rdel, input int mid);
        @(negedge clk);
        thr[0] = t0; thr[1] = t1; thr[2] = t2; thr[3] = t3;
        wait_cycles = WW'(wcyc);
        lim = (wcyc < 16) ? 16 : wcyc;
        noise_en = noisy; rdy_delay = rdel;
        mrq.delete();
        for (int l = 0; l < L; l++) begin mrq.push_back('h80); got_pulses[l] = 0; end
        mrq.push_back(0);
        enter_cnt = 0; cur_lane = 0; gap_exp = 0; in_burst = 0; run_done = 0;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        chk(err == 1'b0, "R9 error cleared by start", int'(err), 0);
        chk(mr_valid == 1'b1, "R2 enter write after start", int'(mr_valid), 1);
        if (mid > 0) begin
            repeat (mid) @(negedge clk);
            start = 1'b1;
            @(negedge clk); start = 1'b0;
        end
        while (!run_done) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        for (int l = 0; l < L; l++) begin thr[l] = 100; got_pulses[l] = 0; end
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(done == 0,      "R1 done after reset",      int'(done), 0);
        chk(err == 0,       "R1 err after reset",       int'(err), 0);
        chk(mr_valid == 0,  "R1 mr_valid after reset",  int'(mr_valid), 0);
        chk(dqs_pulse == 0, "R1 pulses after reset",    int'(dqs_pulse), 0);
        chk(dly_tap == 0,   "R1 delays after reset",    int'(dly_tap), 0);
        chk(lane_fail == 0, "R1 lane_fail after reset", int'(lane_fail), 0);
        // varied thresholds, top tap locks on lane 3
        run(5, 1, 12, 31, 20, 0, 0, 0);
        // R8: all-ones and never-one lanes; short wait clamps to 16; noisy; slow ready
        run(0, 40, 7, 3, 4, 1, 3, 0);
        chk(err == 1'b1, "R9 error held after run", int'(err), 1);
        // R10: start pulsed mid-run; R9: error cleared by the new start
        run(2, 2, 2, 2, 16, 1, 1, 150);
        chk(err == 1'b0, "R9 error clear after clean run", int'(err), 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule